// File: doc/BRIEF.md
# Loop Secondary Station Bit Repeater

This block sits on the serial side of a station that shares a ring with other stations and a ring controller. While idle it passes every line bit through to its own output one bit time late, so the ring stays closed through it. It watches the received stream for the poll-release pattern: a zero followed by seven ones. When software has asked the station to go active, it flips the last one of that pattern as it leaves the one-bit delay stage. The pattern then leaves the station as a flag (a zero, six ones, a zero), which opens the station's own frame.

After seizing the ring, the station takes bits from a local source, one per bit strobe, and drops the received bits. When the local source signals the end of its message, the station sends its own poll-release pattern and returns to repeating. The go-active request is then consumed. Two event outputs mark the moment a poll-release pattern is recognised on the received line and the moment that condition ends. Bit stuffing and frame check sequences are handled elsewhere.

Top module: `sdlc_loop_station`

## Requirements
- R1: After reset, tx_bit is 1, and active, loc_req, eop_seen and eop_gone are all 0.
- R2: While active is 0, each clock with bit_en high loads tx_bit with the rx_bit of that clock. In clocks with bit_en low, tx_bit holds its value.
- R3: eop_seen is a one-clock pulse in the clock after a bit_en clock whose rx_bit is 1 and whose previous seven sampled bits were, oldest first, 0,1,1,1,1,1,1. The pattern is checked in arrival order.
- R4: Once a pattern of R3 has been recognised, the next bit_en clock with rx_bit 0 ends the condition. eop_gone pulses for one clock after that bit_en clock.
- R5: A request is pending if go_active was high in some clock before the bit_en clock that delivered the pattern's leading zero. If such a request is pending and active is 0, the bit_en clock that completes the pattern loads tx_bit with 0 instead of 1, and active rises at that same edge.
- R6: A go_active pulse given after the pattern's leading zero has been sampled does not convert that pattern; its final one is repeated. The next complete pattern is converted.
- R7: While the station is sending its message, loc_req is 1, and each bit_en clock with loc_done low loads tx_bit with loc_bit. rx_bit is not repeated.
- R8: A bit_en clock with loc_done high during the message loads tx_bit with 0. The next seven bit_en clocks load 1, and loc_req is 0 during these eight bits. active falls at the seventh of them, and the bit_en clock after that repeats rx_bit again.
- R9: The request is cleared when the closing pattern of R8 finishes. A later pattern is repeated unchanged unless go_active is pulsed again.
- R10: If go_active is never raised, active stays 0 and every pattern is repeated unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-clock strobe per bit time |
| rx_bit | input | 1 | Received line bit, sampled when bit_en is high |
| go_active | input | 1 | Request to seize the ring at the next poll-release pattern |
| loc_bit | input | 1 | Local message bit, taken on each bit_en while sending |
| loc_done | input | 1 | Local message finished, sampled on bit_en while sending |
| tx_bit | output | 1 | Transmitted line bit |
| eop_seen | output | 1 | Pulse: poll-release pattern recognised |
| eop_gone | output | 1 | Pulse: poll-release condition ended |
| active | output | 1 | Station owns its output (message or closing pattern) |
| loc_req | output | 1 | Station is consuming local message bits |

## Verification
The hardest case to reach is a request that lands between a pattern's leading zero and its final one. Random traffic seldom hits that window, and if it does it looks like an ordinary conversion. The stimulus therefore sends a zero, pulses go_active, and then sends the seven ones by hand. It checks that this pattern passes unchanged and that the following one is converted. A random phase then injects whole patterns into biased random traffic, with gapped bit strobes and random request and end-of-message timing. A bench model predicts every output.

// File: rtl/sdlc_loop_pkg.sv
package sdlc_loop_pkg;
   typedef enum logic [1:0] {
      ST_REPEAT = 2'd0,
      ST_LOCAL  = 2'd1,
      ST_TRAIL  = 2'd2
   } stn_state_t;
endpackage

// File: rtl/sdlc_loop_eop_det.sv
module sdlc_loop_eop_det #(
   parameter int ONES_LEN = 7,
   parameter bit EVT_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   output logic match,
   output logic eop_seen,
   output logic eop_gone
);
   // pattern window: oldest bit is the leading zero, the rest ones
   localparam logic [ONES_LEN-1:0] PAT_HEAD = {1'b0, {(ONES_LEN-1){1'b1}}};

   logic [ONES_LEN-1:0] hist_q;
   logic                cond_q;
   logic                gone_now;

   assign match    = bit_en & rx_bit & (hist_q == PAT_HEAD);
   assign gone_now = bit_en & ~rx_bit & cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '1;
         cond_q <= 1'b0;
      end else if (bit_en) begin
         hist_q <= {hist_q[ONES_LEN-2:0], rx_bit};
         if (match)
            cond_q <= 1'b1;
         else if (!rx_bit)
            cond_q <= 1'b0;
      end
   end

   generate
      if (EVT_REG) begin : g_evt_reg
         logic seen_q, gone_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= 1'b0;
               gone_q <= 1'b0;
            end else begin
               seen_q <= match;
               gone_q <= gone_now;
            end
         end
         assign eop_seen = seen_q;
         assign eop_gone = gone_q;
      end else begin : g_evt_comb
         assign eop_seen = match;
         assign eop_gone = gone_now;
      end
   endgenerate
endmodule

// File: rtl/sdlc_loop_seq.sv
module sdlc_loop_seq
   import sdlc_loop_pkg::*;
#(
   parameter int ONES_LEN = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       rx_bit,
   input  logic       match,
   input  logic       go_active,
   input  logic       loc_done,
   output stn_state_t state,
   output logic       conv
);
   localparam int CNT_W = (ONES_LEN > 2) ? $clog2(ONES_LEN) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ONES_LEN - 1);

   stn_state_t       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             req_q;
   logic             cand_q;
   logic             trail_end;

   assign conv      = match & cand_q & req_q & (state_q == ST_REPEAT);
   assign trail_end = bit_en & (state_q == ST_TRAIL) & (cnt_q == CNT_LAST);
   assign state     = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_REPEAT;
         cnt_q   <= '0;
      end else if (bit_en) begin
         unique case (state_q)
            ST_REPEAT: if (conv) state_q <= ST_LOCAL;
            ST_LOCAL: if (loc_done) begin
               state_q <= ST_TRAIL;
               cnt_q   <= '0;
            end
            ST_TRAIL: if (cnt_q == CNT_LAST) state_q <= ST_REPEAT;
                      else                   cnt_q   <= cnt_q + 1'b1;
            default: state_q <= ST_REPEAT;
         endcase
      end
   end

   // request is sticky until the closing pattern is out; a new pulse wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         req_q <= 1'b0;
      else if (go_active)
         req_q <= 1'b1;
      else if (trail_end)
         req_q <= 1'b0;
   end

   // a pattern may be taken only if the request predates its leading zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cand_q <= 1'b0;
      else if (!req_q)
         cand_q <= 1'b0;
      else if (bit_en && !rx_bit)
         cand_q <= 1'b1;
   end
endmodule

// File: rtl/sdlc_loop_txsel.sv
module sdlc_loop_txsel
   import sdlc_loop_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  stn_state_t state,
   input  logic       conv,
   input  logic       rx_bit,
   input  logic       loc_bit,
   input  logic       loc_done,
   output logic       tx_bit
);
   logic tx_d;

   always_comb begin
      unique case (state)
         ST_REPEAT: tx_d = rx_bit & ~conv;
         ST_LOCAL:  tx_d = loc_done ? 1'b0 : loc_bit;
         ST_TRAIL:  tx_d = 1'b1;
         default:   tx_d = 1'b1;
      endcase
   end

   // the one-bit delay stage; conversion forces its zero here
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_bit <= 1'b1;
      else if (bit_en)
         tx_bit <= tx_d;
   end
endmodule

// File: rtl/sdlc_loop_station.sv
module sdlc_loop_station
   import sdlc_loop_pkg::*;
#(
   parameter int ONES_LEN = 7,
   parameter bit EVT_REG  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic go_active,
   input  logic loc_bit,
   input  logic loc_done,
   output logic tx_bit,
   output logic eop_seen,
   output logic eop_gone,
   output logic active,
   output logic loc_req
);
   generate
      if (ONES_LEN < 2 || ONES_LEN > 32) begin : g_bad_len
         $error("ONES_LEN must lie in 2..32");
      end
   endgenerate

   logic       match;
   logic       conv;
   stn_state_t state;

   sdlc_loop_eop_det #(.ONES_LEN(ONES_LEN), .EVT_REG(EVT_REG)) det_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .match(match), .eop_seen(eop_seen), .eop_gone(eop_gone)
   );

   sdlc_loop_seq #(.ONES_LEN(ONES_LEN)) seq_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .match(match), .go_active(go_active), .loc_done(loc_done),
      .state(state), .conv(conv)
   );

   sdlc_loop_txsel txsel_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .state(state),
      .conv(conv), .rx_bit(rx_bit), .loc_bit(loc_bit),
      .loc_done(loc_done), .tx_bit(tx_bit)
   );

   assign active  = (state != ST_REPEAT);
   assign loc_req = (state == ST_LOCAL);
endmodule

// File: rtl/sdlc_loop_station_chk.sv
module sdlc_loop_station_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic rx_bit,
   input logic tx_bit,
   input logic eop_seen,
   input logic eop_gone,
   input logic active,
   input logic loc_req
);
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   p_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !active) |=> (active || tx_bit == $past(rx_bit)));

   p_seen_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eop_seen |=> !eop_seen);

   p_evt_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(eop_seen && eop_gone));

   p_seize_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> (tx_bit == 1'b0 && loc_req));

   p_req_in_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loc_req |-> active);

   p_active_edge_on_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(active));
endmodule

bind sdlc_loop_station sdlc_loop_station_chk chk_i (
   .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
   .tx_bit(tx_bit), .eop_seen(eop_seen), .eop_gone(eop_gone),
   .active(active), .loc_req(loc_req)
);

// File: tb/sdlc_loop_station_tb_top.sv
module sdlc_loop_station_tb_top;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_en = 1'b0, rx_bit = 1'b1, go_active = 1'b0;
   logic loc_bit = 1'b0, loc_done = 1'b0;
   logic tx_bit, eop_seen, eop_gone, active, loc_req;

   int total = 0;
   int bad   = 0;
   bit done_f = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   sdlc_loop_station dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
      .go_active(go_active), .loc_bit(loc_bit), .loc_done(loc_done),
      .tx_bit(tx_bit), .eop_seen(eop_seen), .eop_gone(eop_gone),
      .active(active), .loc_req(loc_req)
   );

   // bench model (0 repeat, 1 message, 2 closing pattern)
   logic [6:0] m_hist;
   logic       m_cond, m_req, m_cand, m_tx, m_seen, m_gone;
   int         m_st, m_cnt;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit pat_hit(input logic [6:0] h, input logic be, input logic rx);
      return be && rx && (h == 7'b0111111);
   endfunction

   task automatic model_reset();
      m_hist = '1; m_cond = 0; m_req = 0; m_cand = 0; m_tx = 1;
      m_seen = 0; m_gone = 0; m_st = 0; m_cnt = 0;
   endtask

   task automatic step(input logic be, input logic rx, input logic ga,
                       input logic lb, input logic ld);
      bit    hit, cv, clr;
      string txtag;
      int    pst;
      @(negedge clk);
      bit_en = be; rx_bit = rx; go_active = ga; loc_bit = lb; loc_done = ld;
      hit = pat_hit(m_hist, be, rx);
      cv  = hit && m_cand && m_req && (m_st == 0);
      clr = 0;
      pst = m_st;
      m_seen = hit;
      m_gone = be && !rx && m_cond;
      if (be) begin
         if (hit) m_cond = 1; else if (!rx) m_cond = 0;
         if (m_st == 0) begin
            m_tx = cv ? 1'b0 : rx;
            if (cv) m_st = 1;
         end else if (m_st == 1) begin
            if (ld) begin m_tx = 0; m_st = 2; m_cnt = 0; end
            else m_tx = lb;
         end else begin
            m_tx = 1;
            if (m_cnt == 6) begin m_st = 0; clr = 1; end else m_cnt++;
         end
      end
      if (!m_req) m_cand = 0; else if (be && !rx) m_cand = 1;
      if (ga) m_req = 1; else if (clr) m_req = 0;
      if (be) m_hist = {m_hist[5:0], rx};
      @(posedge clk);
      #1;
      txtag = (pst == 1) ? "R7 tx" : (pst == 2) ? "R8 tx" : cv ? "R5 tx" : "R2 tx";
      chk(tx_bit === m_tx, txtag, tx_bit, m_tx);
      chk(active === (m_st != 0), "R5 active", active, m_st != 0);
      chk(loc_req === (m_st == 1), "R7 loc_req", loc_req, m_st == 1);
      chk(eop_seen === m_seen, "R3 eop_seen", eop_seen, m_seen);
      chk(eop_gone === m_gone, "R4 eop_gone", eop_gone, m_gone);
   endtask

   task automatic send_pat();
      step(1, 0, 0, 0, 0);
      for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done_f) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int inj;
      logic be, rx, ga, ld;
      void'($urandom(32'd24681));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk(tx_bit === 1'b1 && active === 1'b0 && loc_req === 1'b0 &&
          eop_seen === 1'b0 && eop_gone === 1'b0, "R1 reset",
          {tx_bit, active, loc_req, eop_seen, eop_gone}, 5'b10000);
      @(negedge clk); rst_n = 1'b1;

      // R2 plain repeating with gaps
      for (int i = 0; i < 20; i++) step(1'($urandom % 2), 1'($urandom % 2), 0, 0, 0);

      // R10: pattern without a request is repeated intact
      send_pat();
      chk(tx_bit === 1'b1 && active === 1'b0, "R10 no seize", active, 0);
      step(1, 0, 0, 0, 0);   // ends condition: R4

      // R5: request first, then the pattern is seized
      step(0, 1, 1, 0, 0);
      send_pat();
      chk(tx_bit === 1'b0 && active === 1'b1, "R5 seize", tx_bit, 0);
      for (int i = 0; i < 12; i++) step(1, 1'($urandom % 2), 0, 1'($urandom % 2), 0);
      step(1, 1, 0, 1, 1);   // R8 closing pattern begins
      chk(tx_bit === 1'b0 && loc_req === 1'b0, "R8 close zero", tx_bit, 0);
      for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
      chk(active === 1'b0 && tx_bit === 1'b1, "R8 back to repeat", active, 0);
      step(1, 0, 0, 0, 0);
      chk(tx_bit === 1'b0, "R8 repeat resumes", tx_bit, 0);

      // R9: request consumed, next pattern passes
      send_pat();
      chk(active === 1'b0 && tx_bit === 1'b1, "R9 request cleared", active, 0);

      // R6: request after the leading zero waits for the next pattern
      step(1, 0, 0, 0, 0);
      step(0, 1, 1, 0, 0);
      for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0);
      chk(active === 1'b0 && tx_bit === 1'b1, "R6 late request waits", active, 0);
      send_pat();
      chk(active === 1'b1 && tx_bit === 1'b0, "R6 next pattern seized", active, 1);
      step(1, 0, 0, 0, 1);
      for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0);

      // random phase with injected patterns
      inj = 0;
      for (int n = 0; n < 4000; n++) begin
         be = ($urandom % 10) < 7;
         if (be && inj > 0) begin
            rx = (inj == 8) ? 1'b0 : 1'b1;
            inj--;
         end else begin
            rx = ($urandom % 4) != 0;
            if (be && ($urandom % 25) == 0) inj = 8;
         end
         ga = ($urandom % 60) == 0;
         ld = ($urandom % 15) == 0;
         step(be, rx, ga, 1'($urandom % 2), ld);
      end

      done_f = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule